// File: doc/BRIEF.md
# Privileged Control Register File

This block holds the control registers that privileged and hyper-privileged software uses to steer a processor strand: the trap base addresses, the processor and hyper-processor state words, the current trap level, the interrupt level, the context and partition identifiers used by address translation, eight scratchpad words and the head and tail pointers of four interrupt queues. Software reaches each register through a select code and a write strobe. Every access returns one response a cycle later that carries read data or an error flag.

Each register keeps only the bits it defines, and undefined bits are forced to zero on a write. The trap-program-counter, trap-next-program-counter, trap-state, trap-type and hyper-trap-state registers are stacks with one entry per trap level. An access always uses the entry for the current trap level minus one. Two outputs are also maintained continuously. The first is a packed 64-bit word that gives the translation unit every field it needs from several registers. The second is an interrupt request that is raised when software lowers the trap level to zero outside hyper-privileged mode.

Top module: `priv_ctl_regfile`

## Requirements
- R1: For each cycle with `acc_valid` high, the next cycle has `rsp_valid` high. A cycle without an access has `rsp_valid` low in the next cycle. A write response has `rsp_data` = 0.
- R2: After reset, HPSTATE (select 0x04) reads 0x800, the strand status register (select 0x07) reads 0x50000, `tlz_irq` is 0, and every other register reads 0. FPRS still shows its forced bits, as R4 describes.
- R3: Writes are masked and the masked bits are stored as zero. Trap base (0x00) clears bits 14:0. PSTATE (0x01) keeps bits 12, 9:6 and 4:1 (mask 0x13DE). TL (0x02) keeps 3 bits. PIL (0x03) keeps 4 bits. FPRS (0x08) keeps 3 bits. Partition ID (0x09) keeps 8 bits. The primary context (0x0A) and the secondary context (0x0B) keep 16 bits each. Trap type (0x13) keeps 9 bits. All other registers keep all 64 bits.
- R4: A read of FPRS (0x08) returns the stored value with bits 1:0 set to 1.
- R5: The banked registers are trap PC (0x10), trap next PC (0x11), trap state (0x12), trap type (0x13) and hyper trap state (0x14). They hold one entry per trap level 1..MAX_TL (MAX_TL defaults to 6). A read or write uses the entry at TL-1, so each trap level keeps its own values.
- R6: An access to a banked register while TL is 0 or TL is greater than MAX_TL gives `rsp_err` = 1 and `rsp_data` = 0, and it does not change any stored entry.
- R7: An access to an unimplemented select (0x0D-0x0F, 0x15-0x1F or 0x30-0x3F) gives `rsp_err` = 1 and `rsp_data` = 0, and it changes no state.
- R8: `mmu_ctx` is built from the following fields:
  - bit 0 = HPSTATE[2] (hpriv)
  - bit 1 = HPSTATE[5]
  - bits 3:2 = PSTATE[3:2]
  - bits 5:4 = LSU control (0x0C) bits 3:2
  - bits 15:8 = partition ID
  - bits 18:16 = TL
  - bits 47:32 = primary context
  - bits 63:48 = secondary context

  All other bits are zero. The word reflects a write from the next cycle on.
- R9: A write to TL updates `tlz_irq`. It becomes 1 when HPSTATE[0] (tlz) is 1, the new TL is 0 and HPSTATE[2] (hpriv) is 0. Otherwise it becomes 0. Any access other than a TL write leaves `tlz_irq` unchanged.
- R10: The scratchpad registers occupy selects 0x20-0x27. The queue pointers occupy selects 0x28-0x2F, as head then tail for the CPU-mondo, device-mondo, resumable-error and nonresumable-error queues in that order. Each of these registers is an independent 64-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 6 | Register select |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's access |
| rsp_err | output | 1 | Previous access hit an unimplemented select or an invalid trap level |
| rsp_data | output | 64 | Read data, or zero for writes and errors |
| mmu_ctx | output | 64 | Packed translation context word |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
All-ones write patterns are used against each masked register, so that a mask that is too wide or too narrow shows up as a wrong read-back. Banked registers are written with different values at trap levels 1 and 2 and then read back after the level changes; this tells a stack indexed by TL-1 apart from a single shared register or an off-by-one index. Accesses at trap level 0 and at level 7 test the range check. The packed context word is checked after every contributing register holds a distinct nonzero value, so that a field that is swapped or shifted cannot go unnoticed. The trap-level-zero request is driven through each combination of tlz and hpriv, and through writes to registers other than TL, to show that the request depends on both HPSTATE bits and changes only when TL is written.

// File: rtl/priv_regs_pkg.sv
package priv_regs_pkg;

    localparam int XLEN       = 64;
    localparam int SEL_W      = 6;
    localparam int IDX_W      = 5;
    localparam int TL_W       = 3;
    localparam int NUM_SCALAR = 13;
    localparam int NUM_BANK   = 5;
    localparam int NUM_SPAD   = 8;
    localparam int NUM_QUEUE  = 4;
    localparam int NUM_AUX    = NUM_SPAD + 2 * NUM_QUEUE;

    localparam logic [SEL_W-1:0] BANK_BASE = 6'h10;
    localparam logic [SEL_W-1:0] AUX_BASE  = 6'h20;

    // scalar register indices (equal to their select codes)
    localparam int S_TBA    = 0;
    localparam int S_PSTATE = 1;
    localparam int S_TL     = 2;
    localparam int S_PIL    = 3;
    localparam int S_HPST   = 4;
    localparam int S_HTBA   = 5;
    localparam int S_HINTP  = 6;
    localparam int S_STRAND = 7;
    localparam int S_FPRS   = 8;
    localparam int S_PART   = 9;
    localparam int S_PCTX   = 10;
    localparam int S_SCTX   = 11;
    localparam int S_LSU    = 12;

    // banked register indices (select minus BANK_BASE)
    localparam int B_TPC    = 0;
    localparam int B_TNPC   = 1;
    localparam int B_TSTATE = 2;
    localparam int B_TTYPE  = 3;
    localparam int B_HTST   = 4;

    // HPSTATE bit positions
    localparam int HP_TLZ   = 0;
    localparam int HP_HPRIV = 2;
    localparam int HP_RED   = 5;

    localparam logic [XLEN-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;

    typedef enum logic [1:0] {
        K_NONE,
        K_SCALAR,
        K_BANK,
        K_AUX
    } sel_kind_e;

    typedef struct packed {
        sel_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } sel_dec_t;

    function automatic logic [XLEN-1:0] scalar_mask(input int i);
        case (i)
            S_TBA:    return ~64'h7FFF;
            S_PSTATE: return PSTATE_KEEP;
            S_TL:     return XLEN'((1 << TL_W) - 1);
            S_PIL:    return 64'hF;
            S_FPRS:   return 64'h7;
            S_PART:   return 64'hFF;
            S_PCTX:   return 64'hFFFF;
            S_SCTX:   return 64'hFFFF;
            default:  return '1;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] scalar_reset(input int i);
        case (i)
            S_HPST:   return 64'h800;
            S_STRAND: return 64'h5_0000;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] bank_mask(input int i);
        if (i == B_TTYPE) return 64'h1FF;
        return '1;
    endfunction

endpackage

// File: rtl/priv_sel_decode.sv
module priv_sel_decode
    import priv_regs_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output sel_dec_t         dec
);
    localparam logic [SEL_W-1:0] SC_LIM = SEL_W'(NUM_SCALAR);
    localparam logic [SEL_W-1:0] BK_LIM = BANK_BASE + SEL_W'(NUM_BANK);
    localparam logic [SEL_W-1:0] AX_LIM = AUX_BASE + SEL_W'(NUM_AUX);

    always_comb begin
        dec.kind = K_NONE;
        dec.idx  = '0;
        if (sel < SC_LIM) begin
            dec.kind = K_SCALAR;
            dec.idx  = IDX_W'(sel);
        end else if (sel >= BANK_BASE && sel < BK_LIM) begin
            dec.kind = K_BANK;
            dec.idx  = IDX_W'(sel - BANK_BASE);
        end else if (sel >= AUX_BASE && sel < AX_LIM) begin
            dec.kind = K_AUX;
            dec.idx  = IDX_W'(sel - AUX_BASE);
        end
    end
endmodule

// File: rtl/priv_scalar_bank.sv
module priv_scalar_bank
    import priv_regs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  q [NUM_SCALAR]
);
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SCALAR; i++) begin
            if (rst)
                q[i] <= scalar_reset(i);
            else if (we && idx == IDX_W'(i))
                q[i] <= wdata & scalar_mask(i);
        end
    end
endmodule

// File: rtl/priv_trap_stack.sv
module priv_trap_stack
    import priv_regs_pkg::*;
#(
    parameter int MAX_TL = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [TL_W-1:0]  tl,
    input  logic [XLEN-1:0]  wdata,
    output logic [XLEN-1:0]  rdata,
    output logic             lvl_ok
);
    localparam int LVL_W = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

    logic [XLEN-1:0]  mem [NUM_BANK][MAX_TL];
    logic [TL_W-1:0]  tl_m1;
    logic [LVL_W-1:0] ptr;

    assign tl_m1  = tl - TL_W'(1);
    assign ptr    = LVL_W'(tl_m1);
    assign lvl_ok = (tl != '0) && (tl <= TL_W'(MAX_TL));

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANK; b++)
            for (int l = 0; l < MAX_TL; l++)
                if (lvl_ok && idx == IDX_W'(b) && ptr == LVL_W'(l))
                    rdata = mem[b][l];
    end

    always_ff @(posedge clk) begin
        for (int b = 0; b < NUM_BANK; b++)
            for (int l = 0; l < MAX_TL; l++) begin
                if (rst)
                    mem[b][l] <= '0;
                else if (we && lvl_ok && idx == IDX_W'(b) && ptr == LVL_W'(l))
                    mem[b][l] <= wdata & bank_mask(b);
            end
    end
endmodule

// File: rtl/priv_mmu_pack.sv
module priv_mmu_pack
    import priv_regs_pkg::*;
(
    input  logic            hpriv,
    input  logic            red,
    input  logic [1:0]      pst_bits,
    input  logic [1:0]      lsu_bits,
    input  logic [7:0]      part,
    input  logic [TL_W-1:0] tl,
    input  logic [15:0]     pctx,
    input  logic [15:0]     sctx,
    output logic [XLEN-1:0] word
);
    always_comb begin
        word        = '0;
        word[0]     = hpriv;
        word[1]     = red;
        word[3:2]   = pst_bits;
        word[5:4]   = lsu_bits;
        word[15:8]  = part;
        word[16 +: TL_W] = tl;
        word[47:32] = pctx;
        word[63:48] = sctx;
    end
endmodule

// File: rtl/priv_ctl_regfile.sv
module priv_ctl_regfile
    import priv_regs_pkg::*;
#(
    parameter int MAX_TL = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [SEL_W-1:0] acc_sel,
    input  logic [XLEN-1:0]  acc_wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [XLEN-1:0]  rsp_data,
    output logic [XLEN-1:0]  mmu_ctx,
    output logic             tlz_irq
);
    sel_dec_t        dec;
    logic [XLEN-1:0] scalar_q [NUM_SCALAR];
    logic [XLEN-1:0] aux_q [NUM_AUX];
    logic [XLEN-1:0] bank_rdata;
    logic            bank_lvl_ok;
    logic [TL_W-1:0] cur_tl;
    logic [XLEN-1:0] hpst;
    logic            acc_err;
    logic            wr_ok;
    logic            sc_we;
    logic            bk_we;
    logic            ax_we;
    logic [XLEN-1:0] rd_val;
    logic [TL_W-1:0] new_tl;

    priv_sel_decode u_dec (
        .sel (acc_sel),
        .dec (dec)
    );

    assign acc_err = (dec.kind == K_NONE) || (dec.kind == K_BANK && !bank_lvl_ok);
    assign wr_ok   = acc_valid && acc_write && !acc_err;
    assign sc_we   = wr_ok && dec.kind == K_SCALAR;
    assign bk_we   = wr_ok && dec.kind == K_BANK;
    assign ax_we   = wr_ok && dec.kind == K_AUX;

    priv_scalar_bank u_scalar (
        .clk   (clk),
        .rst   (rst),
        .we    (sc_we),
        .idx   (dec.idx),
        .wdata (acc_wdata),
        .q     (scalar_q)
    );

    assign cur_tl = scalar_q[S_TL][TL_W-1:0];
    assign hpst   = scalar_q[S_HPST];

    priv_trap_stack #(.MAX_TL(MAX_TL)) u_trap (
        .clk    (clk),
        .rst    (rst),
        .we     (bk_we),
        .idx    (dec.idx),
        .tl     (cur_tl),
        .wdata  (acc_wdata),
        .rdata  (bank_rdata),
        .lvl_ok (bank_lvl_ok)
    );

    // scratchpad words followed by queue head/tail pairs
    always_ff @(posedge clk) begin
        for (int a = 0; a < NUM_AUX; a++) begin
            if (rst)
                aux_q[a] <= '0;
            else if (ax_we && dec.idx == IDX_W'(a))
                aux_q[a] <= acc_wdata;
        end
    end

    always_comb begin
        rd_val = '0;
        case (dec.kind)
            K_SCALAR: begin
                for (int i = 0; i < NUM_SCALAR; i++)
                    if (dec.idx == IDX_W'(i)) rd_val = scalar_q[i];
                if (dec.idx == IDX_W'(S_FPRS)) rd_val = rd_val | 64'h3;
            end
            K_BANK:  rd_val = bank_rdata;
            K_AUX: begin
                for (int a = 0; a < NUM_AUX; a++)
                    if (dec.idx == IDX_W'(a)) rd_val = aux_q[a];
            end
            default: rd_val = '0;
        endcase
        if (acc_err) rd_val = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_err   <= acc_valid && acc_err;
            rsp_data  <= (acc_valid && !acc_write) ? rd_val : '0;
        end
    end

    assign new_tl = acc_wdata[TL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst)
            tlz_irq <= 1'b0;
        else if (sc_we && dec.idx == IDX_W'(S_TL))
            tlz_irq <= hpst[HP_TLZ] && (new_tl == '0) && !hpst[HP_HPRIV];
    end

    priv_mmu_pack u_pack (
        .hpriv    (hpst[HP_HPRIV]),
        .red      (hpst[HP_RED]),
        .pst_bits (scalar_q[S_PSTATE][3:2]),
        .lsu_bits (scalar_q[S_LSU][3:2]),
        .part     (scalar_q[S_PART][7:0]),
        .tl       (cur_tl),
        .pctx     (scalar_q[S_PCTX][15:0]),
        .sctx     (scalar_q[S_SCTX][15:0]),
        .word     (mmu_ctx)
    );
endmodule

// File: rtl/priv_ctl_regfile_chk.sv
module priv_ctl_regfile_chk
    import priv_regs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [SEL_W-1:0] acc_sel,
    input logic [2:0]       wd_lo,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [XLEN-1:0]  rsp_data,
    input logic [14:0]      mmu_hole,
    input logic [2:0]       mmu_tl,
    input logic             tlz_irq
);
    logic tl_wr;
    logic unimpl;
    assign tl_wr  = acc_valid && acc_write && acc_sel == SEL_W'(S_TL);
    assign unimpl = (acc_sel >= 6'h0D && acc_sel <= 6'h0F) ||
                    (acc_sel >= 6'h15 && acc_sel <= 6'h1F) ||
                    (acc_sel >= 6'h30);

    // R1
    rsp_follow_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);
    // R1
    rsp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);
    // R1
    wr_rsp_zero_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_write |=> rsp_data == '0);
    // R7
    unimpl_err_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && unimpl |=> rsp_err && rsp_data == '0);
    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_data == '0);
    // R3
    pstate_mask_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_sel == SEL_W'(S_PSTATE)
        |=> (rsp_data & ~PSTATE_KEEP) == '0);
    // R4
    fprs_low_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_write && acc_sel == SEL_W'(S_FPRS)
        |=> rsp_data[1:0] == 2'b11);
    // R8
    mmu_hole_chk: assert property (@(posedge clk) disable iff (rst)
        mmu_hole == '0);
    // R8
    mmu_tl_chk: assert property (@(posedge clk) disable iff (rst)
        tl_wr |=> mmu_tl == $past(wd_lo));
    // R9
    tlz_clear_chk: assert property (@(posedge clk) disable iff (rst)
        tl_wr && wd_lo != 3'd0 |=> !tlz_irq);
    // R9
    tlz_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tl_wr |=> $stable(tlz_irq));
endmodule

bind priv_ctl_regfile priv_ctl_regfile_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_sel   (acc_sel),
    .wd_lo     (acc_wdata[2:0]),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_data  (rsp_data),
    .mmu_hole  ({mmu_ctx[31:19], mmu_ctx[7:6]}),
    .mmu_tl    (mmu_ctx[18:16]),
    .tlz_irq   (tlz_irq)
);

// File: tb/priv_ctl_regfile_bench.sv
`timescale 1ns/1ps
module priv_ctl_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_sel = '0;
    logic [63:0] acc_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_data;
    logic [63:0] mmu_ctx;
    logic        tlz_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    typedef struct {
        logic [63:0] data;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    priv_ctl_regfile u_priv_ctl_regfile (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_sel   (acc_sel),
        .acc_wdata (acc_wdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_data  (rsp_data),
        .mmu_ctx   (mmu_ctx),
        .tlz_irq   (tlz_irq)
    );

    task automatic access(input bit wr, input logic [5:0] sel, input logic [63:0] wd,
                          input logic [63:0] exp_d, input bit exp_e, input string tag);
        exp_t e;
        acc_valid = 1'b1;
        acc_write = wr;
        acc_sel   = sel;
        acc_wdata = wd;
        e.data = wr ? 64'h0 : exp_d;
        e.err  = exp_e;
        e.tag  = tag;
        sb.push_back(e);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic wr(input logic [5:0] sel, input logic [63:0] wd, input string tag);
        access(1'b1, sel, wd, 64'h0, 1'b0, tag);
    endtask

    task automatic rd(input logic [5:0] sel, input logic [63:0] exp_d, input string tag);
        access(1'b0, sel, 64'h0, exp_d, 1'b0, tag);
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    // monitor: compare each response against the oldest expected item
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            n_chk++;
            if (sb.size() == 0) begin
                n_err++;
                $display("FAIL R1 unexpected response: actual=%h expected=none", rsp_data);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (rsp_data !== e.data || rsp_err !== e.err) begin
                    n_err++;
                    $display("FAIL %s: actual=%h err=%b expected=%h err=%b",
                             e.tag, rsp_data, rsp_err, e.data, e.err);
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2 reset state
        check("R2 tlz_irq reset", {63'h0, tlz_irq}, 64'h0);
        check("R2 mmu_ctx reset", mmu_ctx, 64'h0);
        check("R1 rsp_valid reset", {63'h0, rsp_valid}, 64'h0);
        rd(6'h04, 64'h800,   "R2 HPSTATE reset");
        rd(6'h07, 64'h50000, "R2 strand reset");
        rd(6'h00, 64'h0,     "R2 TBA reset");
        rd(6'h08, 64'h3,     "R2 R4 FPRS reset read");
        rd(6'h25, 64'h0,     "R2 scratch reset");
        @(negedge clk);
        @(negedge clk);
        check("R1 rsp_valid idle", {63'h0, rsp_valid}, 64'h0);

        // R3 masks with all-ones writes
        wr(6'h00, '1, "R3 TBA write");
        rd(6'h00, 64'hFFFF_FFFF_FFFF_8000, "R3 TBA low bits cleared");
        wr(6'h01, '1, "R3 PSTATE write");
        rd(6'h01, 64'h13DE, "R3 PSTATE mask");
        wr(6'h03, '1, "R3 PIL write");
        rd(6'h03, 64'hF, "R3 PIL mask");
        wr(6'h08, 64'hFC, "R3 FPRS write");
        rd(6'h08, 64'h7, "R4 FPRS forced bits");

        // R6 banked access at TL=0
        access(1'b1, 6'h10, 64'h1234, 64'h0, 1'b1, "R6 TPC write TL0");
        access(1'b0, 6'h10, 64'h0,    64'h0, 1'b1, "R6 TPC read TL0");

        // R5 per-level entries
        wr(6'h02, 64'h1, "R5 TL=1");
        rd(6'h10, 64'h0, "R6 TPC entry untouched by TL0 write");
        wr(6'h10, 64'hAAAA, "R5 TPC write L1");
        wr(6'h13, 64'hFFFF, "R3 TT write L1");
        wr(6'h02, 64'h2, "R5 TL=2");
        wr(6'h10, 64'hBBBB, "R5 TPC write L2");
        rd(6'h10, 64'hBBBB, "R5 TPC read L2");
        rd(6'h13, 64'h0,    "R5 TT read L2");
        wr(6'h02, 64'h1, "R5 TL=1 again");
        rd(6'h10, 64'hAAAA, "R5 TPC read L1");
        rd(6'h13, 64'h1FF,  "R3 TT mask L1");

        // R3 TL width, R6 TL beyond MAX_TL
        wr(6'h02, 64'hF, "R3 TL write 0xF");
        rd(6'h02, 64'h7, "R3 TL masked");
        access(1'b1, 6'h14, 64'h55, 64'h0, 1'b1, "R6 HTSTATE write TL7");
        access(1'b0, 6'h11, 64'h0,  64'h0, 1'b1, "R6 TNPC read TL7");

        // R7 unimplemented selects
        access(1'b1, 6'h0D, '1,    64'h0, 1'b1, "R7 write 0x0D");
        access(1'b0, 6'h3F, 64'h0, 64'h0, 1'b1, "R7 read 0x3F");
        access(1'b0, 6'h18, 64'h0, 64'h0, 1'b1, "R7 read 0x18");
        rd(6'h02, 64'h7, "R7 TL unchanged after bad write");

        // R8 packed context word
        wr(6'h04, 64'h24,    "R8 HPSTATE");
        wr(6'h0C, 64'hC,     "R8 LSU");
        wr(6'h09, 64'h1A5,   "R8 partition");
        wr(6'h0A, 64'h12345, "R8 primary ctx");
        wr(6'h0B, 64'hBEEF,  "R8 secondary ctx");
        rd(6'h09, 64'hA5,    "R3 partition mask");
        rd(6'h0A, 64'h2345,  "R3 primary ctx mask");
        check("R8 mmu_ctx packing", mmu_ctx, 64'hBEEF_2345_0007_A53F);

        // R9 trap-level-zero request
        wr(6'h04, 64'h1, "R9 HPSTATE tlz");
        check("R9 tlz unchanged by HPSTATE write", {63'h0, tlz_irq}, 64'h0);
        wr(6'h02, 64'h0, "R9 TL=0");
        check("R9 tlz raised", {63'h0, tlz_irq}, 64'h1);
        wr(6'h20, 64'h9, "R9 unrelated write");
        check("R9 tlz held", {63'h0, tlz_irq}, 64'h1);
        wr(6'h02, 64'h1, "R9 TL=1");
        check("R9 tlz cleared by TL=1", {63'h0, tlz_irq}, 64'h0);
        wr(6'h04, 64'h5, "R9 HPSTATE tlz+hpriv");
        wr(6'h02, 64'h0, "R9 TL=0 hpriv");
        check("R9 tlz blocked by hpriv", {63'h0, tlz_irq}, 64'h0);
        wr(6'h04, 64'h0, "R9 HPSTATE clear");
        wr(6'h02, 64'h0, "R9 TL=0 no tlz");
        check("R9 tlz needs tlz bit", {63'h0, tlz_irq}, 64'h0);

        // R10 scratchpad and queue registers
        for (int i = 0; i < 16; i++)
            wr(6'(32 + i), 64'hC0DE_0000_0000_0000 | 64'(i * 17), "R10 aux write");
        for (int i = 0; i < 16; i++)
            rd(6'(32 + i), 64'hC0DE_0000_0000_0000 | 64'(i * 17), "R10 aux read");

        repeat (3) @(negedge clk);
        check("R1 all responses seen", 64'(sb.size()), 64'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule